// File: doc/BRIEF.md
# Hierarchical Interrupt Identification Controller

This block gathers interrupt events from six peripheral modules and one group of system sources. It reduces them to a single registered interrupt request and a service address for a small processor core. Every source owns a sticky flag that latches on its event, whatever the enable settings. Each flag is gated by a local enable. The module selected by `MEN_MASK` is also gated by a module-wide enable.

Flags are grouped into functions of `FPF` flags each. A function's gated flags are ORed into one function interrupt. The modules named in `MID_MASK` expose their function interrupts as a 16-bit identification field, so a service routine can see which function fired. A summary vector holds one bit per module plus one bit for the system group. That vector is masked per bit and gated by a global enable to form the request. Every request is served from one programmable vector register.

Software clears a flag by writing a 1 to it. A flag that is never cleared keeps its request pending indefinitely.

Top module: `hiic_ctrl`

## Requirements
- R1: A flag sets on the clock after its event input is high. This holds when its local enable, module enable and global enable are all 0.
- R2: A set flag stays set until a 1 is applied to its clear bit. It then reads 0 on the next clock. Clear bits of other flags have no effect on it.
- R3: When a flag's event and clear are high in the same cycle, the flag is set afterwards.
- R4: In a module with an identification field, bit f of the field is 1 when any flag with index j in f*FPF to f*FPF+FPF-1 (FPF=3) is set with its local enable high and the module enable passes. Field bits NFUNC (4) and above read 0.
- R5: A module without an identification field (modules 0, 2 and 3 by default) reads 0 across its whole field, even while its functions are pending.
- R6: Summary bit m (m from 0 to 5) is the OR of all gated functions of module m. Summary bit 6 is set when any system flag is set with its system enable high.
- R7: The module enable gates only module 5 (the default `MEN_MASK`). The module enable bits of the other modules have no effect.
- R8: `irq_o` equals the value of (global enable AND any summary bit with its mask bit high) from the previous clock.
- R9: The vector output resets to 0000h. It loads the write data on the clock after a write strobe and holds its value when no write occurs.
- R10: After reset, all flags, identification fields, summary bits and `irq_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 72 | Event inputs, module m flag j at bit m*12+j |
| clr_i | input | 72 | Write-1-to-clear pulses, same layout as evt_i |
| flag_en_i | input | 72 | Local enables, same layout as evt_i |
| mod_en_i | input | 6 | Module enables (used only where MEN_MASK is set) |
| sys_evt_i | input | 4 | System event inputs |
| sys_clr_i | input | 4 | System flag clear pulses |
| sys_en_i | input | 4 | System local enables |
| mask_i | input | 7 | Per-summary-bit mask, bit 6 for the system group |
| glb_en_i | input | 1 | Global interrupt enable |
| vec_we_i | input | 1 | Vector register write strobe |
| vec_d_i | input | 16 | Vector register write data |
| flag_o | output | 72 | Sticky flag state |
| sys_flag_o | output | 4 | System flag state |
| mid_o | output | 96 | Per-module identification fields, module m at bits m*16 and up |
| id_top_o | output | 7 | Module summary, bit 6 for the system group |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 16 | Service address |

## Verification
A vector table places one event at a time across different modules and function positions. For each event it varies the local and module enables. This separates sources that latch but are gated out from sources that reach the summary, and separates modules that show a function field from modules that only show a summary bit. Directed sequences then cover the remaining cases:
- two flags sharing one function, to confirm the OR inside a function;
- coincident set and clear;
- the system group;
- stepping the global enable and masks, to pin the one-cycle request latency;
- vector writes followed by idle cycles.

// File: rtl/hiic_pkg.sv
package hiic_pkg;
   localparam int unsigned HIIC_NMOD  = 6;
   localparam int unsigned HIIC_NFUNC = 4;
   localparam int unsigned HIIC_FPF   = 3;
   localparam int unsigned HIIC_ID_W  = 16;
   localparam int unsigned HIIC_SYS_N = 4;
   localparam int unsigned HIIC_VEC_W = 16;

   // request path state of the summary stage
   typedef enum logic {
      REQ_IDLE = 1'b0,
      REQ_LIVE = 1'b1
   } hiic_req_e;
endpackage

// File: rtl/hiic_flag_bank.sv
module hiic_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   if (N < 1) begin : g_bad_n
      $error("hiic_flag_bank: N must be at least 1");
   end

   logic [N-1:0] flag_q;

   // set has priority over a coincident clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/hiic_module_unit.sv
module hiic_module_unit #(
   parameter int unsigned NFUNC   = 4,
   parameter int unsigned FPF     = 3,
   parameter int unsigned ID_W    = 16,
   parameter bit          HAS_MEN = 1'b0,
   parameter bit          HAS_MID = 1'b0,
   localparam int unsigned FLG    = NFUNC * FPF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FLG-1:0]  evt_i,
   input  logic [FLG-1:0]  clr_i,
   input  logic [FLG-1:0]  le_i,
   input  logic            men_i,
   output logic [FLG-1:0]  flag_o,
   output logic [ID_W-1:0] mid_o,
   output logic            pend_o
);
   if (NFUNC > ID_W) begin : g_bad_w
      $error("hiic_module_unit: NFUNC exceeds ID_W");
   end

   logic             men_eff;
   logic [FLG-1:0]   gated;
   logic [NFUNC-1:0] fint;

   hiic_flag_bank #(.N(FLG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_i),
      .clr_i  (clr_i),
      .flag_o (flag_o)
   );

   // a module without its own enable always passes
   assign men_eff = men_i | !HAS_MEN;
   assign gated   = flag_o & le_i & {FLG{men_eff}};

   for (genvar f = 0; f < NFUNC; f++) begin : g_func
      assign fint[f] = |gated[f*FPF +: FPF];
   end

   assign pend_o = |fint;

   if (HAS_MID) begin : g_mid
      always_comb begin
         mid_o = '0;
         mid_o[NFUNC-1:0] = fint;
      end
   end else begin : g_nomid
      assign mid_o = '0;
   end
endmodule

// File: rtl/hiic_req_reg.sv
module hiic_req_reg import hiic_pkg::*; #(
   parameter int unsigned TOP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en_i,
   input  logic [TOP_W-1:0] mask_i,
   input  logic [TOP_W-1:0] pend_i,
   output logic             irq_o
);
   hiic_req_e req_d, req_q;

   assign req_d = (glb_en_i && |(pend_i & mask_i)) ? REQ_LIVE : REQ_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= REQ_IDLE;
      else        req_q <= req_d;
   end

   assign irq_o = (req_q == REQ_LIVE);
endmodule

// File: rtl/hiic_vector_reg.sv
module hiic_vector_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    vec_q <= '0;
      else if (we_i) vec_q <= d_i;
   end

   assign q_o = vec_q;
endmodule

// File: rtl/hiic_ctrl.sv
module hiic_ctrl import hiic_pkg::*; #(
   parameter int unsigned NMOD  = HIIC_NMOD,
   parameter int unsigned NFUNC = HIIC_NFUNC,
   parameter int unsigned FPF   = HIIC_FPF,
   parameter int unsigned ID_W  = HIIC_ID_W,
   parameter int unsigned SYS_N = HIIC_SYS_N,
   parameter int unsigned VEC_W = HIIC_VEC_W,
   parameter logic [NMOD-1:0] MID_MASK = 6'b110010,
   parameter logic [NMOD-1:0] MEN_MASK = 6'b100000,
   localparam int unsigned FLG   = NFUNC * FPF,
   localparam int unsigned ALLF  = NMOD * FLG,
   localparam int unsigned TOP_W = NMOD + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ALLF-1:0]      evt_i,
   input  logic [ALLF-1:0]      clr_i,
   input  logic [ALLF-1:0]      flag_en_i,
   input  logic [NMOD-1:0]      mod_en_i,
   input  logic [SYS_N-1:0]     sys_evt_i,
   input  logic [SYS_N-1:0]     sys_clr_i,
   input  logic [SYS_N-1:0]     sys_en_i,
   input  logic [TOP_W-1:0]     mask_i,
   input  logic                 glb_en_i,
   input  logic                 vec_we_i,
   input  logic [VEC_W-1:0]     vec_d_i,
   output logic [ALLF-1:0]      flag_o,
   output logic [SYS_N-1:0]     sys_flag_o,
   output logic [NMOD*ID_W-1:0] mid_o,
   output logic [TOP_W-1:0]     id_top_o,
   output logic                 irq_o,
   output logic [VEC_W-1:0]     vec_o
);
   if (NMOD < 1 || FPF < 1 || NFUNC < 1) begin : g_bad_cnt
      $error("hiic_ctrl: module, function and flag counts must be nonzero");
   end
   if (NFUNC > ID_W) begin : g_bad_id
      $error("hiic_ctrl: functions do not fit the identification field");
   end
   if (SYS_N < 1 || VEC_W < 1) begin : g_bad_sys
      $error("hiic_ctrl: system group and vector need a nonzero width");
   end

   for (genvar m = 0; m < NMOD; m++) begin : g_mod
      hiic_module_unit #(
         .NFUNC   (NFUNC),
         .FPF     (FPF),
         .ID_W    (ID_W),
         .HAS_MEN (MEN_MASK[m]),
         .HAS_MID (MID_MASK[m])
      ) u_unit (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt_i[m*FLG +: FLG]),
         .clr_i  (clr_i[m*FLG +: FLG]),
         .le_i   (flag_en_i[m*FLG +: FLG]),
         .men_i  (mod_en_i[m]),
         .flag_o (flag_o[m*FLG +: FLG]),
         .mid_o  (mid_o[m*ID_W +: ID_W]),
         .pend_o (id_top_o[m])
      );
   end

   hiic_flag_bank #(.N(SYS_N)) u_sys (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sys_evt_i),
      .clr_i  (sys_clr_i),
      .flag_o (sys_flag_o)
   );

   assign id_top_o[NMOD] = |(sys_flag_o & sys_en_i);

   hiic_req_reg #(.TOP_W(TOP_W)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en_i (glb_en_i),
      .mask_i   (mask_i),
      .pend_i   (id_top_o),
      .irq_o    (irq_o)
   );

   hiic_vector_reg #(.W(VEC_W)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (vec_we_i),
      .d_i   (vec_d_i),
      .q_o   (vec_o)
   );
endmodule

// File: rtl/hiic_chk.sv
module hiic_chk #(
   parameter int unsigned NMOD  = 6,
   parameter int unsigned ID_W  = 16,
   parameter int unsigned ALLF  = 72,
   parameter int unsigned TOP_W = 7,
   parameter int unsigned VEC_W = 16,
   parameter logic [NMOD-1:0] MID_MASK = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ALLF-1:0]      evt_i,
   input logic [ALLF-1:0]      clr_i,
   input logic [TOP_W-1:0]     mask_i,
   input logic                 glb_en_i,
   input logic                 vec_we_i,
   input logic [VEC_W-1:0]     vec_d_i,
   input logic [ALLF-1:0]      flag_o,
   input logic [NMOD*ID_W-1:0] mid_o,
   input logic [TOP_W-1:0]     id_top_o,
   input logic                 irq_o,
   input logic [VEC_W-1:0]     vec_o
);
   a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_o & $past(evt_i)) == $past(evt_i)));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flag_o) & ~$past(clr_i) & ~flag_o) == '0));

   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_o & $past(clr_i & ~evt_i)) == '0));

   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & clr_i)) |=> ((flag_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

   a_r8_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(glb_en_i && |(id_top_o & mask_i))));

   a_r9_vec_load: assert property (@(posedge clk) disable iff (!rst_n)
      vec_we_i |=> (vec_o == $past(vec_d_i)));

   a_r9_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_we_i |=> $stable(vec_o));

   for (genvar m = 0; m < NMOD; m++) begin : g_id
      if (MID_MASK[m]) begin : g_has
         a_r4_field_vs_top: assert property (@(posedge clk) disable iff (!rst_n)
            id_top_o[m] == (|mid_o[m*ID_W +: ID_W]));
      end
   end
endmodule

bind hiic_ctrl hiic_chk #(
   .NMOD     (NMOD),
   .ID_W     (ID_W),
   .ALLF     (ALLF),
   .TOP_W    (TOP_W),
   .VEC_W    (VEC_W),
   .MID_MASK (MID_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_i    (evt_i),
   .clr_i    (clr_i),
   .mask_i   (mask_i),
   .glb_en_i (glb_en_i),
   .vec_we_i (vec_we_i),
   .vec_d_i  (vec_d_i),
   .flag_o   (flag_o),
   .mid_o    (mid_o),
   .id_top_o (id_top_o),
   .irq_o    (irq_o),
   .vec_o    (vec_o)
);

// File: tb/sim_hiic_ctrl.sv
module sim_hiic_ctrl;
   localparam int CLK_P = 10;
   localparam int FLG   = 12;
   localparam int ALLF  = 72;
   localparam int NMOD  = 6;

   typedef struct packed {
      logic [2:0] m;
      logic [3:0] j;
      logic       le;
      logic       men;
      logic       et;
      logic       em;
   } vec_t;

   // module, flag, local en, module en, expected summary, expected field bit
   localparam vec_t TBL [8] = '{
      '{3'd1, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1},
      '{3'd1, 4'd5,  1'b0, 1'b1, 1'b0, 1'b0},
      '{3'd5, 4'd2,  1'b1, 1'b0, 1'b0, 1'b0},
      '{3'd5, 4'd11, 1'b1, 1'b1, 1'b1, 1'b1},
      '{3'd4, 4'd7,  1'b1, 1'b0, 1'b1, 1'b1},
      '{3'd0, 4'd4,  1'b1, 1'b1, 1'b1, 1'b0},
      '{3'd3, 4'd10, 1'b1, 1'b0, 1'b1, 1'b0},
      '{3'd2, 4'd3,  1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [ALLF-1:0] evt = '0, clr = '0, fen = '0;
   logic [5:0]      men = '0;
   logic [3:0]      sevt = '0, sclr = '0, sen = '0;
   logic [6:0]      mask = '0;
   logic            gen = 1'b0, vwe = 1'b0;
   logic [15:0]     vd = '0;
   logic [ALLF-1:0] flag;
   logic [3:0]      sflag;
   logic [95:0]     mid;
   logic [6:0]      idt;
   logic            irq;
   logic [15:0]     vec;

   int total = 0;
   int bad   = 0;
   int k, f, m;

   always #(CLK_P/2) clk = ~clk;

   hiic_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .flag_en_i(fen),
      .mod_en_i(men), .sys_evt_i(sevt), .sys_clr_i(sclr), .sys_en_i(sen),
      .mask_i(mask), .glb_en_i(gen), .vec_we_i(vwe), .vec_d_i(vd),
      .flag_o(flag), .sys_flag_o(sflag), .mid_o(mid), .id_top_o(idt),
      .irq_o(irq), .vec_o(vec)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); clr = '1; sclr = '1;
      @(negedge clk); clr = '0; sclr = '0;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk); evt[idx] = 1'b1;
      @(negedge clk); evt = '0;
   endtask

   initial begin
      #(CLK_P*150000);
      bad++; total++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 flags", flag, '0);
      chk("R10 summary", idt, '0);
      chk("R10 fields", mid, '0);
      chk("R10 irq", irq, 1'b0);
      chk("R9 vec reset", vec, 16'h0000);

      // table walk, global enable off throughout
      for (int i = 0; i < 8; i++) begin
         m = TBL[i].m;
         k = m*FLG + TBL[i].j;
         f = TBL[i].j / 3;
         @(negedge clk);
         fen = '0; fen[k] = TBL[i].le; men = {6{TBL[i].men}};
         pulse(k);
         chk("R1 flag latched", flag[k], 1'b1);
         chk("R6 R7 summary bit", idt[m], TBL[i].et);
         chk("R4 R5 field", mid[m*16 +: 16], {15'd0, TBL[i].em} << f);
         chk("R8 irq off", irq, 1'b0);
         clear_all();
      end
      chk("R2 clear all", flag, '0);

      // R2: hold and selective clear
      fen = '0; men = '0;
      pulse(13);
      repeat (3) @(negedge clk);
      chk("R2 hold", flag[13], 1'b1);
      clr[14] = 1'b1; @(negedge clk); clr = '0;
      chk("R2 other clear", flag[13], 1'b1);
      clr[13] = 1'b1; @(negedge clk); clr = '0;
      chk("R2 cleared", flag[13], 1'b0);

      // R3: set wins
      @(negedge clk); evt[20] = 1'b1; clr[20] = 1'b1;
      @(negedge clk); evt = '0; clr = '0;
      chk("R3 set wins", flag[20], 1'b1);
      clear_all();

      // R4: two flags in one function of module 4 (f=1, j=3,4)
      fen[51] = 1'b1; fen[52] = 1'b1;
      @(negedge clk); evt[51] = 1'b1; evt[52] = 1'b1;
      @(negedge clk); evt = '0;
      chk("R4 function or", mid[64 +: 16], 16'h0002);
      clr[51] = 1'b1; @(negedge clk); clr = '0;
      chk("R4 one flag left", mid[64 +: 16], 16'h0002);
      clr[52] = 1'b1; @(negedge clk); clr = '0;
      chk("R4 function idle", mid[64 +: 16], 16'h0000);
      fen = '0;

      // R6: system group
      sen = 4'b0100;
      @(negedge clk); sevt[1] = 1'b1;
      @(negedge clk); sevt = '0;
      chk("R6 sys disabled", idt[6], 1'b0);
      chk("R1 sys flag", sflag, 4'b0010);
      @(negedge clk); sevt[2] = 1'b1;
      @(negedge clk); sevt = '0;
      chk("R6 sys enabled", idt[6], 1'b1);

      // R8: request gating and latency
      mask = '1;
      repeat (2) @(negedge clk);
      chk("R8 glb off", irq, 1'b0);
      gen = 1'b1; #1;
      chk("R8 not yet", irq, 1'b0);
      @(negedge clk);
      chk("R8 raised", irq, 1'b1);
      mask[6] = 1'b0; #1;
      chk("R8 still up", irq, 1'b1);
      @(negedge clk);
      chk("R8 masked", irq, 1'b0);
      mask[6] = 1'b1;
      @(negedge clk);
      chk("R8 unmasked", irq, 1'b1);
      sclr = 4'b0110; @(negedge clk); sclr = '0;
      @(negedge clk);
      chk("R2 R8 cleared drops", irq, 1'b0);

      // R9: vector register
      vwe = 1'b1; vd = 16'hA5C3;
      @(negedge clk); vwe = 1'b0; vd = 16'h1234;
      chk("R9 load", vec, 16'hA5C3);
      repeat (2) @(negedge clk);
      chk("R9 hold", vec, 16'hA5C3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule